// File: doc/BRIEF.md
# CAN Transceiver Mode Controller

This block is the digital core that picks the operating mode of a high-speed CAN line transceiver. Two select pins come from the protocol controller: `sel_active` and `sel_enable`. Four condition flags also arrive, each already qualified by analog circuits elsewhere: core/IO supply undervoltage, battery undervoltage, battery power-up and wake-up. From these inputs the block chooses one of five modes and drives the enables for the line transmitter, the main receiver, the low-power monitor receiver, the mid-supply split output and the output that keeps external regulators switched on.

The controlled route into the lowest-power mode goes through an intermediate go-to-sleep mode. The device must sit in that mode for `HOLD_CYC` consecutive clock cycles, with the pins unchanged and no wake-up or power-up event, before it reaches sleep. Both supply flags override the pins. Once the device is asleep, a low `sel_active` does not wake it.

The mode register and all enable registers load on the same clock edge. The mode appears as a one-hot vector.

Top module: `can_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first mode change, the mode is standby (`mode_oh` = 5'b00100). In that state `reg_supply_on` and `rx_lp_on` are 1 and `tx_on`, `rx_main_on` and `split_on` are 0.
- R2: The mode encoding is normal = 5'b00001, receive-only = 5'b00010, standby = 5'b00100, go-to-sleep = 5'b01000 and sleep = 5'b10000. With no supply flag set and `sel_active` = 1, the mode after the next clock edge is normal when `sel_enable` = 1 and receive-only when `sel_enable` = 0. This holds from any mode, sleep included.
- R3: With no flag set, `sel_active` = 0 and `sel_enable` = 0, a device outside sleep goes to standby on the next edge.
- R4: With no flag set, `sel_active` = 0 and `sel_enable` = 1, a device outside sleep goes to go-to-sleep on the next edge.
- R5: Go-to-sleep lasts exactly `HOLD_CYC` cycles and then becomes sleep. Leaving go-to-sleep through a wake-up or power-up event, or through a pin change, restarts the count from zero on the next entry.
- R6: When `sel_active` = 0 and `flag_wake` or `flag_pwrup` is 1, the device goes to standby whatever `sel_enable` is. This applies from sleep too.
- R7: `flag_uv_sup` = 1 puts the device in sleep on the next edge, whatever the pins and the other flags are.
- R8: With `flag_uv_sup` = 0, `flag_uv_bat` = 1 forces standby on the next edge whatever the pins are. When the flag clears, the device returns to the mode the pins select.
- R9: In sleep, with no flag set and `sel_active` = 0, the device stays in sleep for either level of `sel_enable`.
- R10: `reg_supply_on` is 1 in every mode except sleep.
- R11: `tx_on` is 1 only in normal. `rx_main_on` and `split_on` are 1 only in normal and receive-only. `rx_lp_on` is 1 exactly when `rx_main_on` is 0.
- R12: `mode_oh` always has exactly one bit set, and each enable output takes its new value on the same edge as the mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_active | input | 1 | Controller select: 1 = communicating modes, 0 = low-power modes |
| sel_enable | input | 1 | Controller select: picks normal vs receive-only, or go-to-sleep vs standby |
| flag_uv_sup | input | 1 | Core or IO supply undervoltage, qualified |
| flag_uv_bat | input | 1 | Battery undervoltage, qualified |
| flag_pwrup | input | 1 | Battery power-up event flag |
| flag_wake | input | 1 | Wake-up event flag (bus or local) |
| mode_oh | output | 5 | One-hot current mode |
| tx_on | output | 1 | Line transmitter enable |
| rx_main_on | output | 1 | Main receiver enable |
| rx_lp_on | output | 1 | Low-power monitor receiver enable |
| split_on | output | 1 | Mid-supply split output enable |
| reg_supply_on | output | 1 | External regulator switch-on output |

## Verification
The bench counts the go-to-sleep dwell cycle by cycle. A counter that is off by one enters sleep one cycle early or late, and the check at cycle `HOLD_CYC` or `HOLD_CYC+1` catches it. A wake-up event is injected partway through go-to-sleep and the mode is then re-entered. A counter that is not cleared on exit would reach sleep too soon. The bench also drives the standby and go-to-sleep pin combinations while the device is asleep, which exposes a design that wrongly wakes on them. It sets both supply flags together to test priority, and it clears the battery flag to confirm the return to the pin-selected mode. An enable decoded from the wrong mode, or registered one cycle late, shows up against the one-hot mode in the same sample.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [4:0] {
    MODE_NORM  = 5'b00001,
    MODE_RXO   = 5'b00010,
    MODE_STBY  = 5'b00100,
    MODE_GTS   = 5'b01000,
    MODE_SLEEP = 5'b10000
  } mode_e;

  typedef struct packed {
    logic tx;
    logic rx_main;
    logic rx_lp;
    logic split;
    logic reg_sup;
  } drive_s;

  localparam drive_s DRIVE_RESET = '{tx: 1'b0, rx_main: 1'b0, rx_lp: 1'b1,
                                     split: 1'b0, reg_sup: 1'b1};

endpackage

// File: rtl/can_mode_hold_timer.sv
module can_mode_hold_timer #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_gts,
  output logic hold_done
);
  localparam int CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_upd;

  always_comb begin
    cnt_d = cnt_q;
    if (!in_gts)
      cnt_d = '0;
    else if (cnt_q != LAST)
      cnt_d = cnt_q + CW'(1);
  end

  assign cnt_upd = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_upd)
      cnt_q <= cnt_d;
  end

  assign hold_done = in_gts && (cnt_q == LAST);

  // R5: any exit from go-to-sleep restarts the dwell count
  a_r5_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !in_gts |=> cnt_q == '0);
  // R5: the count never runs past the hold limit
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/can_mode_next.sv
module can_mode_next
  import can_mode_pkg::*;
(
  input  mode_e cur,
  input  logic  sel_active,
  input  logic  sel_enable,
  input  logic  flag_uv_sup,
  input  logic  flag_uv_bat,
  input  logic  flag_pwrup,
  input  logic  flag_wake,
  input  logic  hold_done,
  output mode_e nxt
);
  logic event_seen;
  assign event_seen = flag_wake | flag_pwrup;

  always_comb begin
    nxt = cur;
    if (flag_uv_sup)
      nxt = MODE_SLEEP;
    else if (flag_uv_bat)
      nxt = MODE_STBY;
    else if (sel_active)
      nxt = sel_enable ? MODE_NORM : MODE_RXO;
    else if (event_seen)
      nxt = MODE_STBY;
    else if (cur == MODE_SLEEP)
      nxt = MODE_SLEEP;
    else if (!sel_enable)
      nxt = MODE_STBY;
    else if (hold_done)
      nxt = MODE_SLEEP;
    else
      nxt = MODE_GTS;
  end

endmodule

// File: rtl/can_mode_drive.sv
module can_mode_drive
  import can_mode_pkg::*;
(
  input  mode_e  mode,
  output drive_s drv
);
  always_comb begin
    drv = DRIVE_RESET;
    case (mode)
      MODE_NORM:  drv = '{tx: 1'b1, rx_main: 1'b1, rx_lp: 1'b0, split: 1'b1, reg_sup: 1'b1};
      MODE_RXO:   drv = '{tx: 1'b0, rx_main: 1'b1, rx_lp: 1'b0, split: 1'b1, reg_sup: 1'b1};
      MODE_SLEEP: drv = '{tx: 1'b0, rx_main: 1'b0, rx_lp: 1'b1, split: 1'b0, reg_sup: 1'b0};
      default:    drv = DRIVE_RESET;
    endcase
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_active,
  input  logic       sel_enable,
  input  logic       flag_uv_sup,
  input  logic       flag_uv_bat,
  input  logic       flag_pwrup,
  input  logic       flag_wake,
  output logic [4:0] mode_oh,
  output logic       tx_on,
  output logic       rx_main_on,
  output logic       rx_lp_on,
  output logic       split_on,
  output logic       reg_supply_on
);
  mode_e  mode_q, mode_d;
  drive_s drv_q, drv_d;
  logic   hold_done;
  logic   mode_upd;

  can_mode_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_gts    (mode_q == MODE_GTS),
    .hold_done (hold_done)
  );

  can_mode_next u_next (
    .cur         (mode_q),
    .sel_active  (sel_active),
    .sel_enable  (sel_enable),
    .flag_uv_sup (flag_uv_sup),
    .flag_uv_bat (flag_uv_bat),
    .flag_pwrup  (flag_pwrup),
    .flag_wake   (flag_wake),
    .hold_done   (hold_done),
    .nxt         (mode_d)
  );

  can_mode_drive u_drive (
    .mode (mode_d),
    .drv  (drv_d)
  );

  assign mode_upd = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STBY;
      drv_q  <= DRIVE_RESET;
    end else if (mode_upd) begin
      mode_q <= mode_d;
      drv_q  <= drv_d;
    end
  end

  assign mode_oh       = mode_q;
  assign tx_on         = drv_q.tx;
  assign rx_main_on    = drv_q.rx_main;
  assign rx_lp_on      = drv_q.rx_lp;
  assign split_on      = drv_q.split;
  assign reg_supply_on = drv_q.reg_sup;

  a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);
  a_r7_uv_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    flag_uv_sup |=> mode_oh == 5'b10000);
  a_r8_bat_stby: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_uv_sup && flag_uv_bat) |=> mode_oh == 5'b00100);
  a_r10_reg_sup: assert property (@(posedge clk) disable iff (!rst_n)
    reg_supply_on == !mode_oh[4]);
  a_r11_tx_norm: assert property (@(posedge clk) disable iff (!rst_n)
    tx_on |-> mode_oh[0]);
  a_r11_rx_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lp_on != rx_main_on);
  a_r5_sleep_via_gts: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[4] && !$past(mode_oh[4]) && !$past(flag_uv_sup)) |-> $past(mode_oh[3]));
  a_r9_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[4] && !sel_active && !flag_wake && !flag_pwrup && !flag_uv_bat) |=> mode_oh[4]);

endmodule

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  localparam logic [4:0] NORM = 5'b00001, RXO = 5'b00010, STBY = 5'b00100,
                         GTS = 5'b01000, SLP = 5'b10000;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_active, sel_enable, flag_uv_sup, flag_uv_bat, flag_pwrup, flag_wake;
  logic [4:0] mode_oh;
  logic tx_on, rx_main_on, rx_lp_on, split_on, reg_supply_on;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [4:0] mode;
    string      req;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_ctrl #(.HOLD_CYC(HOLD)) i_can_mode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sel_active(sel_active), .sel_enable(sel_enable),
    .flag_uv_sup(flag_uv_sup), .flag_uv_bat(flag_uv_bat),
    .flag_pwrup(flag_pwrup), .flag_wake(flag_wake),
    .mode_oh(mode_oh), .tx_on(tx_on), .rx_main_on(rx_main_on),
    .rx_lp_on(rx_lp_on), .split_on(split_on), .reg_supply_on(reg_supply_on)
  );

  // expected {tx, rx_main, rx_lp, split, reg_sup} per R10/R11
  function automatic logic [4:0] drv_of(logic [4:0] m);
    case (m)
      NORM:    return 5'b11011;
      RXO:     return 5'b01011;
      SLP:     return 5'b00100;
      default: return 5'b00101;
    endcase
  endfunction

  task automatic compare(logic [4:0] m, string req);
    logic [4:0] got_drv;
    got_drv = {tx_on, rx_main_on, rx_lp_on, split_on, reg_supply_on};
    checks++;
    if (mode_oh !== m || got_drv !== drv_of(m)) begin
      fails++;
      $display("FAIL %s: mode=%b drv=%b expected mode=%b drv=%b (t=%0t)",
               req, mode_oh, got_drv, m, drv_of(m), $time);
    end
  endtask

  // monitor: pops expected items once the design has produced them
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.mode, e.req);
    end
  end

  // driver: apply inputs, let one edge pass, queue the expectation
  task automatic step(logic a, logic e, logic us, logic ub, logic pw, logic wk,
                      logic [4:0] exp_mode, string req);
    exp_t it;
    @(negedge clk);
    sel_active = a; sel_enable = e; flag_uv_sup = us;
    flag_uv_bat = ub; flag_pwrup = pw; flag_wake = wk;
    @(posedge clk);
    #1;
    it.mode = exp_mode;
    it.req  = req;
    sb.push_back(it);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    sel_active = 0; sel_enable = 1; flag_uv_sup = 0; flag_uv_bat = 0;
    flag_pwrup = 0; flag_wake = 0;
    repeat (3) @(negedge clk);
    compare(STBY, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // pins still select go-to-sleep, so the first edge after release moves there
    step(0, 0, 0, 0, 0, 0, STBY, "R1 after release");

    step(1, 1, 0, 0, 0, 0, NORM, "R2 normal");
    step(1, 1, 0, 0, 0, 1, NORM, "R2 wake ignored when active");
    step(1, 0, 0, 0, 0, 0, RXO,  "R2 receive-only");
    step(0, 0, 0, 0, 0, 0, STBY, "R3 standby");
    step(1, 1, 0, 0, 0, 0, NORM, "R2 normal again");

    // R5 dwell: HOLD cycles in go-to-sleep, then sleep
    for (int i = 0; i < HOLD; i++) step(0, 1, 0, 0, 0, 0, GTS, "R4/R5 go-to-sleep dwell");
    step(0, 1, 0, 0, 0, 0, SLP, "R5 sleep after hold");

    step(0, 1, 0, 0, 0, 0, SLP, "R9 stays asleep en=1");
    step(0, 0, 0, 0, 0, 0, SLP, "R9 stays asleep en=0");
    step(0, 0, 0, 0, 0, 1, STBY, "R6 wake leaves sleep");
    step(0, 0, 0, 0, 0, 0, STBY, "R3 standby held");

    // interrupted dwell then restart
    for (int i = 0; i < HOLD-2; i++) step(0, 1, 0, 0, 0, 0, GTS, "R4 go-to-sleep");
    step(0, 1, 0, 0, 0, 1, STBY, "R6 wake aborts go-to-sleep");
    for (int i = 0; i < HOLD; i++) step(0, 1, 0, 0, 0, 0, GTS, "R5 restarted dwell");
    step(0, 1, 0, 0, 0, 0, SLP, "R5 sleep after restarted hold");

    step(1, 0, 0, 0, 0, 0, RXO,  "R2 receive-only from sleep");
    step(0, 1, 0, 0, 1, 0, STBY, "R6 power-up forces standby en=1");
    step(0, 0, 0, 0, 1, 0, STBY, "R6 power-up forces standby en=0");

    step(1, 1, 1, 0, 0, 0, SLP,  "R7 supply undervoltage from pins normal");
    step(1, 1, 0, 0, 0, 0, NORM, "R2 normal after supply recovers");
    step(1, 1, 0, 1, 0, 0, STBY, "R8 battery undervoltage forces standby");
    step(1, 0, 0, 1, 0, 0, STBY, "R8 battery flag overrides pins");
    step(1, 1, 0, 0, 0, 0, NORM, "R8 back to pin mode");
    step(1, 1, 1, 1, 1, 1, SLP,  "R7 supply flag has top priority");
    step(0, 0, 0, 0, 0, 0, SLP,  "R9 standby pins keep sleep");
    step(1, 0, 0, 0, 0, 0, RXO,  "R12 enables follow mode on same edge");

    @(negedge clk);
    @(negedge clk);
    summary();
  end

endmodule